// File: doc/BRIEF.md
# Performance monitor counter unit

This block counts processor activity for profiling. It holds a bank of event counters and one cycle counter. Each event counter is given an event number that picks what it counts: one of the external event input lines, or increments requested by software through a register write. The cycle counter advances on every clock, or once every 64 clocks when the prescaler is selected.

Software reaches everything through a flat register port with a write strobe, an address, write data and combinational read data. The event counters are reached indirectly: a select register picks one counter, and two window registers then read or write that counter's count and its event number.

Counter enables, overflow flags and interrupt enables share one bit map. Bit i belongs to event counter i, and bit 31 belongs to the cycle counter. When a counter wraps, it raises its overflow flag, which can drive the single interrupt line. Each counter also carries a programmable action that the block takes when that counter wraps.

Top module: `pmu_unit`

## Requirements
- R1: After reset, every counter, enable, overflow flag, interrupt enable, action and event number is zero, and `irq` is low.
- R2: Reading the control register (address 0) returns the implementer code in [31:24], the identification code in [23:16], the number of event counters in [15:11], the prescaler select in bit 3 and the global enable in bit 0. Every other bit reads 0.
- R3: A write to the enable-set register (address 1) sets each enable whose write-data bit is 1. A write to the enable-clear register (address 2) clears each enable whose write-data bit is 1. Bits 0..3 belong to event counters 0..3 and bit 31 to the cycle counter. A 0 bit leaves its enable unchanged. Reading either address returns the enable mask.
- R4: An enabled event counter increments at a clock edge when the global enable (control bit 0) is set and its selected event is active. Clearing the global enable freezes every counter and leaves the individual enable bits unchanged.
- R5: Event number 0x40+k counts external input `ev_ext[k]` for k = 0..3. Event number 0 counts writes to the software-increment register (address 11) that have a 1 in the bit of that counter's index. Any other event number never counts.
- R6: The select register (address 6) picks an event counter. The count window (address 7) and the event-number window (address 8) read and write the selected counter. With a select value of 4 or more, the windows read 0 and writes to them are ignored.
- R7: The cycle counter (address 9, read and write) counts every active clock. With control bit 3 set, it counts only every 64th active clock.
- R8: Writing 1 to control bit 1 zeroes all event counters. Writing 1 to control bit 2 zeroes the cycle counter and its prescaler. Both bits read back as 0.
- R9: A counter that steps from all-ones to zero sets its flag in the overflow register (address 3). Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high while any overflow flag is set whose interrupt enable is also set. Interrupt enables are set through address 4 and cleared through address 5, using the same bit map as R3.
- R11: The action register (address 10) holds a 2-bit action per counter: bits [2i+1:2i] for event counter i and [31:30] for the cycle counter. The actions are taken on wrap. 0 does nothing. 1 clears the global enable. 2 clears that counter's own enable. 3 absorbs the next count after the wrap, so the counter stays at 0 for one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_ext | input | 4 | External event inputs, counted while high |
| irq | output | 1 | Overflow interrupt |

## Verification
A register write takes effect at the rising edge where the strobe is high. An external event high during a clock is counted at that clock's rising edge. An overflow flag rises at the same edge as the wrap that causes it, and `irq` and all reads follow those registers with no added cycle. In divided mode, the cycle counter steps on the 64th active edge after its prescaler is cleared. The bench drives inputs on falling edges and counts the rising edges between an enabling write and a freezing write to compute exact counts. The monitor samples read data and `irq` one nanosecond after the falling edge where each read is presented.

// File: rtl/pmu_pkg.sv
// Shared register addresses, overflow action codes and event numbers for the
// performance monitor. Assumes a 4-bit register address.
package pmu_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL   = 4'd0,
        A_ENSET  = 4'd1,
        A_ENCLR  = 4'd2,
        A_OVF    = 4'd3,
        A_IENSET = 4'd4,
        A_IENCLR = 4'd5,
        A_SEL    = 4'd6,
        A_EVCNT  = 4'd7,
        A_EVTYPE = 4'd8,
        A_CYCCNT = 4'd9,
        A_ACTION = 4'd10,
        A_SWINC  = 4'd11
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_HALT = 2'd1,
        ACT_STOP = 2'd2,
        ACT_SKIP = 2'd3
    } ovf_act_e;

    localparam logic [7:0] EVT_SOFT     = 8'h00;
    localparam logic [7:0] EVT_EXT_BASE = 8'h40;
endpackage

// File: rtl/pmu_prescale.sv
// Cycle-counter prescaler. While run is high it emits a tick every clock, or
// once every 2**LOG2 clocks when div_on is set. clr restarts the division.
// Assumes run already folds in the global and cycle-counter enables.
module pmu_prescale #(
    parameter int LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic div_on,
    output logic tick
);
    logic [LOG2-1:0] pcnt_q;

    assign tick = run && (!div_on || (pcnt_q == '1));

    // Advance the divider only while running in divided mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pcnt_q <= '0;
        else if (run && div_on) pcnt_q <= pcnt_q + 1'b1;
    end

    p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_on && !clr) |=> !(tick && div_on));
endmodule

// File: rtl/pmu_counter.sv
// One wrapping counter with clear, load and an optional skip-after-wrap mode.
// Priority is clear over load over increment. wrap is high during the
// increment that takes the count from all-ones to zero.
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         skip_mode,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic skip_pend_q;

    assign wrap = inc && !clr && !load && !skip_pend_q && (count == '1);

    // Count register and pending-skip flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count       <= '0;
            skip_pend_q <= 1'b0;
        end else if (load) begin
            count       <= load_val;
            skip_pend_q <= 1'b0;
        end else if (inc) begin
            if (skip_pend_q) begin
                skip_pend_q <= 1'b0;
            end else begin
                count <= count + 1'b1;
                if (count == '1 && skip_mode) skip_pend_q <= 1'b1;
            end
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr && !load) |=> $stable(count));
    p_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_pend_q && inc && !clr && !load) |=> (count == '0));
endmodule

// File: rtl/pmu_unit.sv
// Performance monitor: NUM_EV event counters plus one cycle counter behind a
// flat register port. Enable, overflow and interrupt-enable masks share one
// bit map (bit i = event counter i, bit 31 = cycle counter).
// Assumes 2 <= NUM_EV <= 15, 2 <= EXT_N <= 64 and CNT_W <= 32.
module pmu_unit
    import pmu_pkg::*;
#(
    parameter int         NUM_EV    = 4,
    parameter int         EXT_N     = 4,
    parameter int         CNT_W     = 32,
    parameter int         DIV_LOG2  = 6,
    parameter logic [7:0] IMPL_CODE = 8'h5A,
    parameter logic [7:0] ID_CODE   = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [EXT_N-1:0]  ev_ext,
    output logic              irq
);
    localparam int SEL_W = 5;
    localparam int EXT_IW = $clog2(EXT_N);
    localparam logic [31:0] MAP_MASK = {1'b1, {(31-NUM_EV){1'b0}}, {NUM_EV{1'b1}}};
    localparam logic [31:0] ACT_MASK = {2'b11, {(30-2*NUM_EV){1'b0}}, {(2*NUM_EV){1'b1}}};

    logic             ge_q, div_q;
    logic [31:0]      en_q, ovf_q, ien_q, act_q;
    logic [SEL_W-1:0] sel_q;
    logic [7:0]       evtype_q [NUM_EV];

    logic [CNT_W-1:0] ev_count [NUM_EV];
    logic [NUM_EV-1:0] ev_wrap;
    logic [CNT_W-1:0] cyc_count;
    logic             cyc_wrap, cyc_tick;
    logic [31:0]      wrap_vec, stop_vec;
    logic             halt_any;

    logic wr_ctrl, wr_enset, wr_enclr, wr_ovf, wr_ienset, wr_ienclr;
    logic wr_sel, wr_evcnt, wr_evtype, wr_cyccnt, wr_action, wr_swinc, sel_ok;

    // Register write decode.
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
        wr_enset  = reg_wr && (reg_addr == A_ENSET);
        wr_enclr  = reg_wr && (reg_addr == A_ENCLR);
        wr_ovf    = reg_wr && (reg_addr == A_OVF);
        wr_ienset = reg_wr && (reg_addr == A_IENSET);
        wr_ienclr = reg_wr && (reg_addr == A_IENCLR);
        wr_sel    = reg_wr && (reg_addr == A_SEL);
        wr_evcnt  = reg_wr && (reg_addr == A_EVCNT);
        wr_evtype = reg_wr && (reg_addr == A_EVTYPE);
        wr_cyccnt = reg_wr && (reg_addr == A_CYCCNT);
        wr_action = reg_wr && (reg_addr == A_ACTION);
        wr_swinc  = reg_wr && (reg_addr == A_SWINC);
        sel_ok    = (sel_q < SEL_W'(NUM_EV));
    end

    // One event counter per slice, each with its own event selection.
    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        logic hit;
        always_comb begin
            if (evtype_q[g] == EVT_SOFT)
                hit = wr_swinc && reg_wdata[g];
            else if (evtype_q[g] >= EVT_EXT_BASE && evtype_q[g] < EVT_EXT_BASE + 8'(EXT_N))
                hit = ev_ext[evtype_q[g][EXT_IW-1:0]];
            else
                hit = 1'b0;
        end
        pmu_counter #(.W(CNT_W)) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (wr_ctrl && reg_wdata[1]),
            .load     (wr_evcnt && sel_ok && (sel_q == SEL_W'(g))),
            .load_val (reg_wdata[CNT_W-1:0]),
            .inc      (ge_q && en_q[g] && hit),
            .skip_mode(act_q[2*g +: 2] == ACT_SKIP),
            .count    (ev_count[g]),
            .wrap     (ev_wrap[g])
        );
    end

    pmu_prescale #(.LOG2(DIV_LOG2)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_ctrl && reg_wdata[2]),
        .run   (ge_q && en_q[31]),
        .div_on(div_q),
        .tick  (cyc_tick)
    );

    pmu_counter #(.W(CNT_W)) i_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_ctrl && reg_wdata[2]),
        .load     (wr_cyccnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .inc      (cyc_tick),
        .skip_mode(act_q[31:30] == ACT_SKIP),
        .count    (cyc_count),
        .wrap     (cyc_wrap)
    );

    // Gather wraps into the shared bit map and decode the overflow actions.
    always_comb begin
        wrap_vec = '0;
        stop_vec = '0;
        wrap_vec[NUM_EV-1:0] = ev_wrap;
        wrap_vec[31] = cyc_wrap;
        halt_any = cyc_wrap && (act_q[31:30] == ACT_HALT);
        stop_vec[31] = cyc_wrap && (act_q[31:30] == ACT_STOP);
        for (int i = 0; i < NUM_EV; i++) begin
            stop_vec[i] = ev_wrap[i] && (act_q[2*i +: 2] == ACT_STOP);
            if (ev_wrap[i] && (act_q[2*i +: 2] == ACT_HALT)) halt_any = 1'b1;
        end
    end

    // Control, mask, action and select registers; hardware actions win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ge_q  <= 1'b0;
            div_q <= 1'b0;
            en_q  <= '0;
            ovf_q <= '0;
            ien_q <= '0;
            act_q <= '0;
            sel_q <= '0;
        end else begin
            if (halt_any)     ge_q <= 1'b0;
            else if (wr_ctrl) ge_q <= reg_wdata[0];
            if (wr_ctrl) div_q <= reg_wdata[3];
            en_q  <= ((en_q | ({32{wr_enset}} & reg_wdata & MAP_MASK))
                      & ~({32{wr_enclr}} & reg_wdata)) & ~stop_vec;
            ovf_q <= (ovf_q & ~({32{wr_ovf}} & reg_wdata)) | wrap_vec;
            ien_q <= (ien_q | ({32{wr_ienset}} & reg_wdata & MAP_MASK))
                     & ~({32{wr_ienclr}} & reg_wdata);
            if (wr_action) act_q <= reg_wdata & ACT_MASK;
            if (wr_sel)    sel_q <= reg_wdata[SEL_W-1:0];
        end
    end

    // Event numbers, written through the window for the selected counter.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_EV; i++) begin
            if (!rst_n) evtype_q[i] <= '0;
            else if (wr_evtype && sel_q == SEL_W'(i)) evtype_q[i] <= reg_wdata[7:0];
        end
    end

    assign irq = |(ovf_q & ien_q);

    // Read mux, including the indirect windows.
    always_comb begin
        logic [CNT_W-1:0] sel_cnt;
        logic [7:0]       sel_type;
        sel_cnt  = '0;
        sel_type = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (sel_q == SEL_W'(i)) begin
                sel_cnt  = ev_count[i];
                sel_type = evtype_q[i];
            end
        end
        case (reg_addr)
            A_CTRL:            reg_rdata = {IMPL_CODE, ID_CODE, 5'(NUM_EV), 7'b0, div_q, 2'b00, ge_q};
            A_ENSET, A_ENCLR:  reg_rdata = en_q;
            A_OVF:             reg_rdata = ovf_q;
            A_IENSET, A_IENCLR: reg_rdata = ien_q;
            A_SEL:             reg_rdata = 32'(sel_q);
            A_EVCNT:           reg_rdata = 32'(sel_cnt);
            A_EVTYPE:          reg_rdata = 32'(sel_type);
            A_CYCCNT:          reg_rdata = 32'(cyc_count);
            A_ACTION:          reg_rdata = act_q;
            default:           reg_rdata = '0;
        endcase
    end

    p_flag_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_q & ~$past(ovf_q) & ~$past(wrap_vec)) == 32'b0));
    p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_vec != 32'b0) |=> ((en_q & $past(stop_vec)) == 32'b0));
    p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_any |=> !ge_q);
    p_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q | ien_q) & ~MAP_MASK) == 32'b0);
endmodule

// File: tb/test_pmu_unit.sv
`timescale 1ns/1ps
module test_pmu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ev_ext = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    localparam logic [31:0] CTRL_ID = 32'h5A13_2000;

    always #2.5 clk = ~clk;

    pmu_unit i_pmu_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_ext(ev_ext), .irq(irq)
    );

    // Monitor: pops expected items and compares just after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver tasks; each starts and ends on a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_irq(input bit e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_ev(input logic [3:0] v, input int n);
        ev_ext = v;
        repeat (n) @(negedge clk);
        ev_ext = '0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk(4'd0, CTRL_ID, "R2 control readback after reset");
        chk(4'd9, 32'h0, "R1 cycle counter reset");
        chk(4'd3, 32'h0, "R1 overflow flags reset");
        chk_irq(1'b0, "R1 irq low after reset");

        wr(4'd6, 0); wr(4'd8, 32'h40);
        wr(4'd6, 1); wr(4'd8, 32'h41);
        wr(4'd6, 2); wr(4'd8, 32'h99);
        wr(4'd6, 3); wr(4'd8, 32'h00);
        chk(4'd8, 32'h0, "R6 event number window for counter 3");
        wr(4'd1, 32'h0000_000F);
        chk(4'd2, 32'h0000_000F, "R3 enable mask via clear address");
        wr(4'd2, 32'h0);
        chk(4'd1, 32'h0000_000F, "R3 zero write to clear has no effect");

        wr(4'd0, 32'h1);
        drive_ev(4'b0011, 3);
        drive_ev(4'b0001, 2);
        drive_ev(4'b0100, 2);
        wr(4'd11, 32'h8);
        wr(4'd11, 32'h9);
        wr(4'd0, 32'h0);
        drive_ev(4'b1111, 4);
        wr(4'd6, 0); chk(4'd7, 32'd5, "R4 external input 0 count");
        wr(4'd6, 1); chk(4'd7, 32'd3, "R5 external input 1 count");
        wr(4'd6, 2); chk(4'd7, 32'd0, "R5 unmapped event number never counts");
        wr(4'd6, 3); chk(4'd7, 32'd2, "R5 software increment count");
        chk(4'd1, 32'h0000_000F, "R4 freeze keeps individual enables");
        chk(4'd0, CTRL_ID, "R4 global enable reads cleared");

        wr(4'd6, 7); wr(4'd7, 32'h55);
        chk(4'd7, 32'h0, "R6 out-of-range select reads 0");
        wr(4'd6, 0);
        chk(4'd7, 32'd5, "R6 out-of-range write ignored");

        wr(4'd0, 32'h2);
        chk(4'd0, CTRL_ID, "R8 reset bits read as 0");
        chk(4'd7, 32'h0, "R8 event counter 0 zeroed");
        wr(4'd6, 3); chk(4'd7, 32'h0, "R8 event counter 3 zeroed");

        wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h1);
        idle(9);
        wr(4'd0, 32'h0);
        chk(4'd9, 32'd10, "R7 undivided cycle count");

        wr(4'd0, 32'hC);
        chk(4'd0, CTRL_ID | 32'h8, "R2 prescaler select reads back");
        wr(4'd0, 32'h9);
        idle(150);
        wr(4'd0, 32'h8);
        chk(4'd9, 32'd2, "R7 divided cycle count");
        wr(4'd0, 32'h4);
        chk(4'd9, 32'd0, "R8 cycle counter zeroed");

        wr(4'd6, 0); wr(4'd7, 32'hFFFF_FFFE);
        wr(4'd0, 32'h1);
        drive_ev(4'b0001, 2);
        wr(4'd0, 32'h0);
        chk(4'd7, 32'h0, "R9 counter wrapped to zero");
        chk(4'd3, 32'h1, "R9 overflow flag set");
        chk_irq(1'b0, "R10 irq masked");
        wr(4'd4, 32'h1);
        chk_irq(1'b1, "R10 irq with enable set");
        chk(4'd5, 32'h1, "R10 interrupt enable readback");
        wr(4'd3, 32'h0);
        chk_irq(1'b1, "R9 zero write leaves flag");
        wr(4'd3, 32'h1);
        chk_irq(1'b0, "R10 irq drops after flag clear");
        chk(4'd3, 32'h0, "R9 flag cleared by write of 1");

        wr(4'd10, 32'h2);
        chk(4'd10, 32'h2, "R11 action register readback");
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd0, 32'h1);
        drive_ev(4'b0001, 1);
        drive_ev(4'b0001, 3);
        wr(4'd0, 32'h0);
        chk(4'd1, 32'h8000_000E, "R11 stop clears own enable");
        chk(4'd7, 32'h0, "R11 stopped counter stays at zero");
        chk_irq(1'b1, "R10 irq from new overflow");
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd5, 32'h1);

        wr(4'd10, 32'hC);
        wr(4'd6, 1); wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd0, 32'h1);
        drive_ev(4'b0010, 3);
        wr(4'd0, 32'h0);
        chk(4'd7, 32'd1, "R11 skip absorbs one count");
        chk(4'd3, 32'h2, "R9 flag of counter 1");

        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd2, 32'hF);
        wr(4'd10, 32'h4000_0000);
        wr(4'd9, 32'hFFFF_FFFE);
        wr(4'd0, 32'h1);
        idle(5);
        chk(4'd0, CTRL_ID, "R11 halt clears global enable");
        chk(4'd9, 32'h0, "R11 cycle counter frozen after halt");
        chk(4'd3, 32'h8000_0000, "R9 cycle counter flag in bit 31");
        wr(4'd4, 32'h8000_0000);
        chk_irq(1'b1, "R10 irq from cycle counter flag");

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule